// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative store of page-to-frame translations placed in front of a memory system. Every stored translation carries the identifier of the address space that owns it. Translations from several processes can therefore live side by side, and a context switch needs no flush. A lookup presents a virtual page number, the current address-space identifier and the kind of access. All slots are compared at once. One cycle later the block answers with a hit and the frame number, or with a miss.

A miss tells an outside page-table walker to fetch the translation. The walker then installs it through the fill port, so the next lookup of that page hits. Every slot holds a two-bit permission code. An access that the code does not allow is flagged as a fault, even when the lookup hits. Software can drop every slot at once, or only the slots of one address space. Two running counters record hits and misses, so the effective access time can be worked out from them.

Top module: `xc_top`

## Requirements
- R1: When `lk_valid` is high, the response appears on the next clock edge with `rsp_valid` high. On a hit, `rsp_pfn` holds the stored frame. When `lk_valid` is low, `rsp_valid` is low one cycle later.
- R2: A hit needs a valid slot whose page number and identifier both equal the lookup's. The same page under another identifier misses.
- R3: A lookup that matches no slot gives `rsp_miss` high, `rsp_hit` low and `rsp_pfn` zero. Once the translation has been filled, a later lookup of it hits.
- R4: Access codes: 0 read, 1 write, 2 execute, 3 reserved (always faults). Permission codes: 0 read only, 1 read and write, 2 execute only, 3 read and execute. On a hit with a disallowed access, `rsp_fault` is high. `rsp_fault` is never high without `rsp_hit`.
- R5: A fill of a new translation goes to the lowest-numbered invalid slot. When all slots are valid, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one only on such a replacement.
- R6: A fill whose page and identifier equal a valid slot rewrites that slot in place. No other slot is disturbed, and the round-robin pointer does not move.
- R7: `flush_all` invalidates every slot. A fill presented in the same cycle as either flush command is dropped.
- R8: A flush by identifier invalidates only the slots tagged with `flush_asid`.
- R9: Every lookup adds one to `hit_cnt` on a hit, faulting hits included, or to `miss_cnt` on a miss.
- R10: After reset, all slots are invalid, both counters are zero and `rsp_valid` is low.
- R11: A lookup in the same cycle as a fill or a flush sees the slot contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the requester |
| lk_kind | input | 2 | Access code |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number being installed |
| fill_asid | input | ASID_W | Identifier being installed |
| fill_pfn | input | PFN_W | Frame number being installed |
| fill_perm | input | 2 | Permission code being installed |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_valid | input | 1 | Invalidate the slots of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent |
| rsp_fault | output | 1 | Hit with disallowed access |
| rsp_pfn | output | PFN_W | Translated frame number |
| hit_cnt | output | CNT_W | Lookups that hit |
| miss_cnt | output | CNT_W | Lookups that missed |

## Verification
After each change of contents, a sweep covers every page number under three identifiers with all four access codes. This tells a page match apart from a full page-and-identifier match, and it tests each permission code against each access kind. The fill sequences run into a full cache, rewrite a resident translation and open a hole with a flush by identifier. Together they separate free-slot placement, round-robin eviction and in-place rewriting. Lookups issued in the same cycle as a fill or a flush show which contents a lookup sees. A run of 98 hits and 2 misses checks the counters against an effective access time of 122 ns.

// File: rtl/xc_pkg.sv
package xc_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PERM_RO = 2'd0,
        PERM_RW = 2'd1,
        PERM_XO = 2'd2,
        PERM_RX = 2'd3
    } perm_e;

    function automatic logic perm_allows(perm_e perm, acc_e kind);
        logic ok;
        case (perm)
            PERM_RO: ok = (kind == ACC_READ);
            PERM_RW: ok = (kind == ACC_READ) || (kind == ACC_WRITE);
            PERM_XO: ok = (kind == ACC_EXEC);
            PERM_RX: ok = (kind == ACC_READ) || (kind == ACC_EXEC);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xc_match.sv
module xc_match #(
    parameter int N      = 4,
    parameter int VPN_W  = 8,
    parameter int ASID_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          valid_vec,
    input  logic [N*VPN_W-1:0]    vpn_flat,
    input  logic [N*ASID_W-1:0]   asid_flat,
    input  logic [VPN_W-1:0]      key_vpn,
    input  logic [ASID_W-1:0]     key_asid,
    output logic                  hit_any,
    output logic [IDX_W-1:0]      hit_idx
);

    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g]
                          && (vpn_flat[g*VPN_W +: VPN_W] == key_vpn)
                          && (asid_flat[g*ASID_W +: ASID_W] == key_asid);
    end

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)) else $error("duplicate translation"); // R6

endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valid_vec,
    input  logic             fill_go,
    input  logic             fill_hit,
    output logic [IDX_W-1:0] vict_idx
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic             replace;

    assign free_any = ~&valid_vec;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign vict_idx = free_any ? free_idx : rr_q;
    assign replace  = fill_go && !fill_hit && !free_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (replace) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : IDX_W'(rr_q + 1'b1);
        end
    end

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (fill_go && !fill_hit && free_any) |-> !valid_vec[vict_idx]) else $error("free slot skipped"); // R5
    AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        replace |=> (rr_q != $past(rr_q))) else $error("pointer stuck"); // R5
    AST_RR_HOLD_REWRITE: assert property (@(posedge clk) disable iff (rst)
        (fill_go && fill_hit) |=> $stable(rr_q)) else $error("pointer moved on rewrite"); // R6

endmodule

// File: rtl/xc_top.sv
module xc_top
    import xc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 8,
    parameter int ASID_W  = 4,
    parameter int PFN_W   = 6,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_kind,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_perm,
    input  logic              flush_all,
    input  logic              flush_asid_valid,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);

    localparam int IDX_W = idx_width(ENTRIES);

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_e             perm;
    } slot_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic             fault;
        logic [PFN_W-1:0] pfn;
    } rsp_t;

    slot_t slot_q [ENTRIES];
    rsp_t  rsp_q;

    logic [ENTRIES-1:0]        valid_vec;
    logic [ENTRIES*VPN_W-1:0]  vpn_flat;
    logic [ENTRIES*ASID_W-1:0] asid_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_vec[g]                   = slot_q[g].valid;
        assign vpn_flat[g*VPN_W +: VPN_W]     = slot_q[g].vpn;
        assign asid_flat[g*ASID_W +: ASID_W]  = slot_q[g].asid;
    end

    // lookup search
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;

    xc_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_lk_match (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .vpn_flat  (vpn_flat),
        .asid_flat (asid_flat),
        .key_vpn   (lk_vpn),
        .key_asid  (lk_asid),
        .hit_any   (lk_hit),
        .hit_idx   (lk_idx)
    );

    // fill search, to rewrite a resident translation in place
    logic             fill_hit;
    logic [IDX_W-1:0] fill_hit_idx;

    xc_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_fill_match (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .vpn_flat  (vpn_flat),
        .asid_flat (asid_flat),
        .key_vpn   (fill_vpn),
        .key_asid  (fill_asid),
        .hit_any   (fill_hit),
        .hit_idx   (fill_hit_idx)
    );

    logic             fill_go;
    logic [IDX_W-1:0] vict_idx;
    logic [IDX_W-1:0] wr_idx;

    assign fill_go = fill_valid && !flush_all && !flush_asid_valid;

    xc_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .fill_go   (fill_go),
        .fill_hit  (fill_hit),
        .vict_idx  (vict_idx)
    );

    assign wr_idx = fill_hit ? fill_hit_idx : vict_idx;

    // slot storage: flush-all, then flush-by-id, then fill
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                slot_q[i].valid <= 1'b0;
            end else if (flush_all) begin
                slot_q[i].valid <= 1'b0;
            end else if (flush_asid_valid) begin
                if (slot_q[i].asid == flush_asid) slot_q[i].valid <= 1'b0;
            end else if (fill_go && (wr_idx == IDX_W'(i))) begin
                slot_q[i] <= '{valid: 1'b1, asid: fill_asid, vpn: fill_vpn,
                               pfn: fill_pfn, perm: perm_e'(fill_perm)};
            end
        end
    end

    // registered response
    slot_t lk_slot;
    logic  lk_allow;

    assign lk_slot  = slot_q[lk_idx];
    assign lk_allow = perm_allows(lk_slot.perm, acc_e'(lk_kind));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= lk_valid;
            rsp_q.hit   <= lk_valid && lk_hit;
            rsp_q.miss  <= lk_valid && !lk_hit;
            rsp_q.fault <= lk_valid && lk_hit && !lk_allow;
            rsp_q.pfn   <= (lk_valid && lk_hit) ? lk_slot.pfn : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_fault = rsp_q.fault;
    assign rsp_pfn   = rsp_q.pfn;

    // hit and miss counters
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else if (lk_valid) begin
            if (lk_hit) hit_cnt  <= hit_cnt + 1'b1;
            else        miss_cnt <= miss_cnt + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid) else $error("response without lookup"); // R1
    AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss)) else $error("hit and miss disagree"); // R3
    AST_MISS_ZERO_PFN: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_pfn == '0)) else $error("frame on miss"); // R3
    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_hit) else $error("fault without hit"); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0)) else $error("slot survived flush"); // R7
    AST_HIT_COUNTED: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |=> (hit_cnt == CNT_W'($past(hit_cnt) + 1'b1))) else $error("hit not counted"); // R9
    AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |=> (miss_cnt == CNT_W'($past(miss_cnt) + 1'b1))) else $error("miss not counted"); // R9

endmodule

// File: tb/tb_xc_top.sv
module tb_xc_top;

    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       lk_valid;
    logic [7:0] lk_vpn;
    logic [3:0] lk_asid;
    logic [1:0] lk_kind;
    logic       fill_valid;
    logic [7:0] fill_vpn;
    logic [3:0] fill_asid;
    logic [5:0] fill_pfn;
    logic [1:0] fill_perm;
    logic       flush_all;
    logic       flush_asid_valid;
    logic [3:0] flush_asid;
    logic       rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [5:0] rsp_pfn;
    logic [15:0] hit_cnt, miss_cnt;

    int checks = 0;
    int errors = 0;

    // requirement model
    bit         m_v    [N];
    logic [7:0] m_vpn  [N];
    logic [3:0] m_asid [N];
    logic [5:0] m_pfn  [N];
    logic [1:0] m_perm [N];
    int         m_rr = 0;

    always #10 clk = ~clk;

    xc_top dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_kind(lk_kind),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_pfn(rsp_pfn), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit allowed(logic [1:0] perm, logic [1:0] kind);
        case (perm)
            2'd0: return kind == 2'd0;
            2'd1: return (kind == 2'd0) || (kind == 2'd1);
            2'd2: return kind == 2'd2;
            default: return (kind == 2'd0) || (kind == 2'd2);
        endcase
    endfunction

    // one cycle: optional lookup, fill and flushes, then check the lookup
    task automatic step(string req, bit lv, int vpn, int asid, int kind,
                        bit fv, int fvpn, int fasid, int fpfn, int fperm,
                        bit fa, bit fi, int fid);
        bit   e_hit = 0;
        bit   e_fault = 0;
        int   e_pfn = 0;
        int   widx = -1;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == 8'(vpn) && m_asid[i] == 4'(asid)) begin
                e_hit = 1;
                e_pfn = int'(m_pfn[i]);
                e_fault = !allowed(m_perm[i], 2'(kind));
            end
        end
        if (fa) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (fi) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == 4'(fid)) m_v[i] = 0;
        end else if (fv) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == 8'(fvpn) && m_asid[i] == 4'(fasid)) widx = i;
            if (widx < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) widx = i;
            end
            if (widx < 0) begin
                widx = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[widx] = 1; m_vpn[widx] = 8'(fvpn); m_asid[widx] = 4'(fasid);
            m_pfn[widx] = 6'(fpfn); m_perm[widx] = 2'(fperm);
        end
        lk_valid = lv; lk_vpn = 8'(vpn); lk_asid = 4'(asid); lk_kind = 2'(kind);
        fill_valid = fv; fill_vpn = 8'(fvpn); fill_asid = 4'(fasid);
        fill_pfn = 6'(fpfn); fill_perm = 2'(fperm);
        flush_all = fa; flush_asid_valid = fi; flush_asid = 4'(fid);
        @(posedge clk);
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_valid = 0;
        if (lv) begin
            check(req, {rsp_valid, rsp_hit, rsp_miss, rsp_fault, 2'b00, rsp_pfn},
                       {1'b1, e_hit, !e_hit, e_fault, 2'b00, 6'(e_pfn)});
        end
    endtask

    task automatic fill(string req, int vpn, int asid, int pfn, int perm);
        step(req, 0, 0, 0, 0, 1, vpn, asid, pfn, perm, 0, 0, 0);
    endtask

    task automatic look(string req, int vpn, int asid, int kind);
        step(req, 1, vpn, asid, kind, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // every page under three identifiers with every access code
    task automatic sweep(string req);
        for (int a = 1; a <= 3; a++)
            for (int p = 0; p < 16; p++)
                for (int k = 0; k < 4; k++)
                    look(req, p, a, k);
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int h0, m0, dh, dm;
        for (int i = 0; i < N; i++) m_v[i] = 0;
        rst = 1; lk_valid = 0; lk_vpn = 0; lk_asid = 0; lk_kind = 0;
        fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0; fill_perm = 0;
        flush_all = 0; flush_asid_valid = 0; flush_asid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        check("R10 rsp_valid", 32'(rsp_valid), 0);
        check("R10 hit_cnt", 32'(hit_cnt), 0);
        check("R10 miss_cnt", 32'(miss_cnt), 0);
        look("R10 empty lookup misses", 3, 1, 0);

        // R1 R2 R4: four translations, two identifiers share page 3
        fill("R1", 3, 1, 10, 1);
        fill("R1", 5, 1, 11, 0);
        fill("R2", 3, 2, 12, 2);
        fill("R4", 9, 2, 13, 3);
        sweep("R1 R2 R4 sweep full");

        // R5: full cache, round-robin from slot 0
        fill("R5", 7, 1, 14, 1);
        sweep("R5 first eviction");
        fill("R5", 8, 1, 15, 0);
        sweep("R5 second eviction");

        // R6: rewrite resident translation in place
        fill("R6", 3, 2, 20, 1);
        sweep("R6 rewrite in place");
        fill("R6", 4, 3, 30, 3);
        sweep("R6 pointer unchanged");

        // R8: flush identifier 2, then refill goes to the lowest hole (R5)
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
        sweep("R8 flush by id");
        fill("R5", 11, 3, 21, 3);
        sweep("R5 free slot first");

        // R11 R3: lookup alongside fill sees old contents, then hits
        step("R11 lookup with fill", 1, 12, 3, 0, 1, 12, 3, 22, 0, 0, 0, 0);
        look("R3 hit after fill", 12, 3, 0);
        look("R3 R4 write to read-only", 12, 3, 1);

        // R7 R11: flush_all drops concurrent fill; lookup sees old contents
        step("R11 lookup with flush", 1, 7, 1, 0, 1, 2, 1, 5, 1, 1, 0, 0);
        sweep("R7 all flushed");

        // R9: 98 hits and 2 misses give 122 ns at 20 ns lookup, 100 ns memory
        fill("R9", 1, 1, 9, 1);
        h0 = int'(hit_cnt); m0 = int'(miss_cnt);
        look("R9 miss", 2, 1, 0);
        look("R9 miss", 2, 2, 0);
        for (int i = 0; i < 98; i++) look("R9 hit", 1, 1, 0);
        dh = int'(hit_cnt) - h0; dm = int'(miss_cnt) - m0;
        check("R9 hits", 32'(dh), 98);
        check("R9 misses", 32'(dm), 2);
        check("R9 access time ns", 32'((dh * 120 + dm * 220) / (dh + dm)), 122);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule